// File: doc/BRIEF.md
# Hardwired Control Step Generator

This block is the hardwired sequencer of a small single-bus processor. A step register moves forward by one control step on each clock and is decoded into one-hot timing lines T1 to T8. Combinational encoder logic joins the active timing line, the decoded opcode and the negative condition flag into the gating strobes the datapath needs: register gates onto and off the bus, the ALU add and constant-four select, memory read, and a wait-for-memory request.

Every instruction begins with the same three fetch steps. The opcode then chooses the rest of the sequence. An end strobe sends the sequencer back to T1 on the next edge. Whenever a step raises the memory-wait strobe, the step register stays where it is until the memory's completion input is high. The datapath, the ALU and the memory are outside this block.

Top module: `hwctl_top`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) puts the sequencer in T1, shown as `stepHot` = 8'b0000_0001. In T1, pcOut, marIn, memRead, sel4, aluAdd and zIn are high and every other strobe is low.
- R2: For every opcode, T2 raises zOut, pcIn, yIn and waitMem, and T3 raises mdrOut and irIn. No other strobes are high in these steps.
- R3: `stepHot` is one-hot, with bit k meaning step T(k+1). With no wait stall and no end, the step moves up by one per clock. The sequencer stays in T8 if it ever gets there without an end.
- R4: When waitMem is high and memDone is low, the step does not change at the clock edge. When memDone is high, the step moves on. Outside wait steps, memDone has no effect.
- R5: Opcode 2'b00 (add from memory): T4 raises marIn and memRead. T5 raises yIn and waitMem. T6 raises mdrOut, aluAdd and zIn. T7 raises zOut and endStep.
- R6: Opcode 2'b01 (unconditional branch): T4 raises offOut, aluAdd and zIn. T5 raises zOut, pcIn and endStep.
- R7: Opcode 2'b10 (branch if negative): T4 raises offOut, aluAdd and zIn. When negFlag is 0, T4 also raises endStep, and pcIn never rises after the fetch. When negFlag is 1, T5 raises zOut, pcIn and endStep.
- R8: Opcode 2'b11 (no operation): T4 raises endStep and no other strobe.
- R9: After a clock edge at which endStep is high and the sequencer is not stalled, the step is T1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 2 | Decoded instruction class: 00 add, 01 branch, 10 branch if negative, 11 no operation |
| negFlag | input | 1 | Negative condition code |
| memDone | input | 1 | Memory reports that the transfer is complete |
| stepHot | output | 8 | One-hot timing lines T1..T8 |
| pcOut | output | 1 | Gate PC onto the bus |
| marIn | output | 1 | Load memory address register |
| memRead | output | 1 | Start memory read |
| sel4 | output | 1 | ALU operand mux selects constant 4 |
| aluAdd | output | 1 | ALU performs add |
| zIn | output | 1 | Load ALU result register |
| zOut | output | 1 | Gate ALU result onto the bus |
| pcIn | output | 1 | Load PC from the bus |
| yIn | output | 1 | Load ALU operand register |
| waitMem | output | 1 | Wait for memory completion |
| mdrOut | output | 1 | Gate memory data register onto the bus |
| irIn | output | 1 | Load instruction register |
| offOut | output | 1 | Gate the branch offset field onto the bus |
| endStep | output | 1 | Last step of the instruction |

## Verification
The embedded properties check on every cycle that the step holds during a memory stall, advances by one or returns to T1 as the strobes command, that the result register is never loaded and driven in the same step, and that fetch steps and a not-taken negative branch drive the correct strobes. What only the bench scenarios show is the whole strobe pattern of each opcode over a full instruction: stalls of different lengths, memDone pulses outside wait steps having no effect, both outcomes of the conditional branch, and a reset that arrives in the middle of an instruction.

// File: rtl/hwctl_pkg.sv
package hwctl_pkg;

  // Instruction classes delivered by the opcode decoder
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_BR  = 2'b01,
    OP_BRN = 2'b10,
    OP_NOP = 2'b11
  } opKind_t;

  // Strobes the encoder hands to the step register
  typedef struct packed {
    logic hold;     // freeze the step (memory stall)
    logic restart;  // return to T1 at the next edge
  } seqStrobe_t;

  // Gating strobes toward the datapath
  typedef struct packed {
    logic pcOut;
    logic marIn;
    logic memRead;
    logic sel4;
    logic aluAdd;
    logic zIn;
    logic zOut;
    logic pcIn;
    logic yIn;
    logic waitMem;
    logic mdrOut;
    logic irIn;
    logic offOut;
    logic endStep;
  } gate_t;

endpackage

// File: rtl/hwctl_step_counter.sv
module hwctl_step_counter
  import hwctl_pkg::*;
#(
  parameter int STEPS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  seqStrobe_t       strobe,
  output logic [STEPS-1:0] stepHot
);

  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  logic [CW-1:0] stepIdx;

  always_ff @(posedge clk) begin
    if (rst)                 stepIdx <= '0;
    else if (strobe.hold)    stepIdx <= stepIdx;
    else if (strobe.restart) stepIdx <= '0;
    else if (stepIdx != LAST) stepIdx <= stepIdx + CW'(1);
  end

  for (genvar g = 0; g < STEPS; g++) begin : g_decode
    assign stepHot[g] = (stepIdx == CW'(g));
  end

  // R4: a stall keeps the step unchanged
  assert_stall_hold_R4 : assert property (@(posedge clk) disable iff (rst)
    strobe.hold |=> $stable(stepIdx));

  // R9: an end without a stall returns to the first step
  assert_restart_t1_R9 : assert property (@(posedge clk) disable iff (rst)
    (strobe.restart && !strobe.hold) |=> stepHot[0]);

  // R3: a free step moves up by exactly one
  assert_advance_R3 : assert property (@(posedge clk) disable iff (rst)
    (!strobe.hold && !strobe.restart && stepIdx != LAST)
      |=> stepIdx == $past(stepIdx) + CW'(1));

  // R3: the last step saturates
  assert_saturate_R3 : assert property (@(posedge clk) disable iff (rst)
    (!strobe.hold && !strobe.restart && stepIdx == LAST) |=> stepIdx == LAST);

endmodule

// File: rtl/hwctl_encoder.sv
module hwctl_encoder
  import hwctl_pkg::*;
#(
  parameter int STEPS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [STEPS-1:0] stepHot,
  input  logic [1:0]       opcode,
  input  logic             negFlag,
  input  logic             memDone,
  output gate_t            gates,
  output seqStrobe_t       strobe
);

  logic t1, t2, t3, t4, t5, t6, t7;
  logic isAdd, isBr, isBrn, isNop;
  logic anyBranch;

  assign t1 = stepHot[0];
  assign t2 = stepHot[1];
  assign t3 = stepHot[2];
  assign t4 = stepHot[3];
  assign t5 = stepHot[4];
  assign t6 = stepHot[5];
  assign t7 = stepHot[6];

  assign isAdd = (opcode == OP_ADD);
  assign isBr  = (opcode == OP_BR);
  assign isBrn = (opcode == OP_BRN);
  assign isNop = (opcode == OP_NOP);
  assign anyBranch = isBr | isBrn;

  always_comb begin
    gates.pcOut   = t1;
    gates.sel4    = t1;
    gates.marIn   = t1 | (t4 & isAdd);
    gates.memRead = t1 | (t4 & isAdd);
    gates.aluAdd  = t1 | (t6 & isAdd) | (t4 & anyBranch);
    gates.zIn     = t1 | (t6 & isAdd) | (t4 & anyBranch);
    gates.zOut    = t2 | (t7 & isAdd) | (t5 & isBr) | (t5 & isBrn & negFlag);
    gates.pcIn    = t2 | (t5 & isBr) | (t5 & isBrn & negFlag);
    gates.yIn     = t2 | (t5 & isAdd);
    gates.waitMem = t2 | (t5 & isAdd);
    gates.mdrOut  = t3 | (t6 & isAdd);
    gates.irIn    = t3;
    gates.offOut  = t4 & anyBranch;
    gates.endStep = (t7 & isAdd) | (t5 & isBr)
                  | (isBrn & ((t5 & negFlag) | (t4 & ~negFlag)))
                  | (t4 & isNop);
  end

  assign strobe.hold    = gates.waitMem & ~memDone;
  assign strobe.restart = gates.endStep;

  // R5: the result register is never loaded and driven in one step
  assert_z_exclusive_R5 : assert property (@(posedge clk) disable iff (rst)
    !(gates.zIn && gates.zOut));

  // R2: the second fetch step waits for memory and updates the PC
  assert_fetch_wait_R2 : assert property (@(posedge clk) disable iff (rst)
    t2 |-> (gates.waitMem && gates.pcIn && !gates.endStep));

  // R7: a branch that is not taken ends at T4 and leaves the PC alone
  assert_brn_not_taken_R7 : assert property (@(posedge clk) disable iff (rst)
    (t4 && isBrn && !negFlag) |-> (gates.endStep && !gates.pcIn));

  // R3: the final timing line drives no strobe
  assert_last_quiet_R3 : assert property (@(posedge clk) disable iff (rst)
    stepHot[STEPS-1] |-> (gates == '0));

endmodule

// File: rtl/hwctl_top.sv
module hwctl_top
  import hwctl_pkg::*;
#(
  parameter int STEPS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       opcode,
  input  logic             negFlag,
  input  logic             memDone,
  output logic [STEPS-1:0] stepHot,
  output logic             pcOut,
  output logic             marIn,
  output logic             memRead,
  output logic             sel4,
  output logic             aluAdd,
  output logic             zIn,
  output logic             zOut,
  output logic             pcIn,
  output logic             yIn,
  output logic             waitMem,
  output logic             mdrOut,
  output logic             irIn,
  output logic             offOut,
  output logic             endStep
);

  seqStrobe_t seqStrobe;
  gate_t      gateBus;

  hwctl_step_counter #(.STEPS(STEPS)) counter_i (
    .clk     (clk),
    .rst     (rst),
    .strobe  (seqStrobe),
    .stepHot (stepHot)
  );

  hwctl_encoder #(.STEPS(STEPS)) encoder_i (
    .clk     (clk),
    .rst     (rst),
    .stepHot (stepHot),
    .opcode  (opcode),
    .negFlag (negFlag),
    .memDone (memDone),
    .gates   (gateBus),
    .strobe  (seqStrobe)
  );

  assign pcOut   = gateBus.pcOut;
  assign marIn   = gateBus.marIn;
  assign memRead = gateBus.memRead;
  assign sel4    = gateBus.sel4;
  assign aluAdd  = gateBus.aluAdd;
  assign zIn     = gateBus.zIn;
  assign zOut    = gateBus.zOut;
  assign pcIn    = gateBus.pcIn;
  assign yIn     = gateBus.yIn;
  assign waitMem = gateBus.waitMem;
  assign mdrOut  = gateBus.mdrOut;
  assign irIn    = gateBus.irIn;
  assign offOut  = gateBus.offOut;
  assign endStep = gateBus.endStep;

endmodule

// File: tb/hwctl_top_tb_top.sv
module hwctl_top_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] opcode = 2'b11;
  logic negFlag = 1'b0;
  logic memDone = 1'b0;
  logic [7:0] stepHot;
  logic pcOut, marIn, memRead, sel4, aluAdd, zIn, zOut, pcIn, yIn;
  logic waitMem, mdrOut, irIn, offOut, endStep;

  always #2.5 clk = ~clk;   // 200 MHz

  hwctl_top dut_i (
    .clk(clk), .rst(rst), .opcode(opcode), .negFlag(negFlag), .memDone(memDone),
    .stepHot(stepHot), .pcOut(pcOut), .marIn(marIn), .memRead(memRead),
    .sel4(sel4), .aluAdd(aluAdd), .zIn(zIn), .zOut(zOut), .pcIn(pcIn),
    .yIn(yIn), .waitMem(waitMem), .mdrOut(mdrOut), .irIn(irIn),
    .offOut(offOut), .endStep(endStep)
  );

  // Bit masks of the observed strobe vector
  localparam logic [13:0] PCO = 14'h2000, MAR = 14'h1000, RD  = 14'h0800,
                          S4  = 14'h0400, ADB = 14'h0200, ZI  = 14'h0100,
                          ZO  = 14'h0080, PCI = 14'h0040, YI  = 14'h0020,
                          WM  = 14'h0010, MDO = 14'h0008, IRI = 14'h0004,
                          OFF = 14'h0002, EN  = 14'h0001;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  int mStep = 1;            // reference step, 1..8
  logic [15:0] lfsr = 16'hACE1;
  string stepTag = "R1";

  function automatic logic [13:0] expVec(int s, logic [1:0] op, logic n);
    logic [13:0] e;
    e = '0;
    case (s)
      1: e = PCO | MAR | RD | S4 | ADB | ZI;
      2: e = ZO | PCI | YI | WM;
      3: e = MDO | IRI;
      default: begin
        if (op == 2'b00) begin
          if (s == 4) e = MAR | RD;
          if (s == 5) e = YI | WM;
          if (s == 6) e = MDO | ADB | ZI;
          if (s == 7) e = ZO | EN;
        end else if (op == 2'b01) begin
          if (s == 4) e = OFF | ADB | ZI;
          if (s == 5) e = ZO | PCI | EN;
        end else if (op == 2'b10) begin
          if (s == 4) e = OFF | ADB | ZI | (n ? 14'h0 : EN);
          if (s == 5 && n) e = ZO | PCI | EN;
        end else begin
          if (s == 4) e = EN;
        end
      end
    endcase
    return e;
  endfunction

  function automatic string opTag(int s, logic [1:0] op);
    if (s <= 3) return "R2";
    case (op)
      2'b00: return "R5";
      2'b01: return "R6";
      2'b10: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic checkNow(logic [1:0] op, logic n);
    logic [13:0] got, exp;
    logic [7:0] expHot;
    expHot = 8'b1 << (mStep - 1);
    checks++;
    if (stepHot !== expHot) begin
      errors++;
      $display("FAIL %s step: got %b expected %b", stepTag, stepHot, expHot);
    end
    got = {pcOut, marIn, memRead, sel4, aluAdd, zIn, zOut, pcIn, yIn,
           waitMem, mdrOut, irIn, offOut, endStep};
    exp = expVec(mStep, op, n);
    checks++;
    if (got[13:1] !== exp[13:1]) begin
      errors++;
      $display("FAIL %s strobes at T%0d: got %b expected %b",
               opTag(mStep, op), mStep, got[13:1], exp[13:1]);
    end
    checks++;
    if (got[0] !== exp[0]) begin
      errors++;
      $display("FAIL %s endStep at T%0d: got %b expected %b",
               opTag(mStep, op), mStep, got[0], exp[0]);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    mStep = 1;
    stepTag = "R1";
  endtask

  // One instruction, checked every cycle against the reference sequence
  task automatic runInstr(logic [1:0] op, logic n, int delay);
    int waitCnt;
    bit done;
    logic [13:0] e;
    waitCnt = 0;
    done = 0;
    opcode = op;
    negFlag = n;
    while (!done) begin
      e = expVec(mStep, op, n);
      if ((e & WM) != 0) memDone = (waitCnt >= delay);
      else               memDone = lfsr[0];  // R4: ignored outside wait
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      #1;
      checkNow(op, n);
      @(posedge clk);
      if ((e & WM) != 0 && !memDone) begin
        waitCnt++;
        stepTag = "R4";
      end else if ((e & EN) != 0) begin
        mStep = 1;
        waitCnt = 0;
        done = 1;
        stepTag = "R9";
      end else begin
        waitCnt = 0;
        if (mStep < 8) mStep++;
        stepTag = "R3";
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    doReset();
    #1;
    checkNow(opcode, negFlag);     // R1 reset state
    @(negedge clk);
    mStep = 2;                      // step moved from T1 with opcode no-op
    stepTag = "R3";
    #1;
    checkNow(opcode, negFlag);
    doReset();
    runInstr(2'b00, 1'b0, 0);       // R5 add, no stall
    runInstr(2'b00, 1'b1, 3);       // R5 add, stall in both waits (R4)
    runInstr(2'b01, 1'b0, 1);       // R6 branch
    runInstr(2'b10, 1'b0, 2);       // R7 not taken
    runInstr(2'b10, 1'b1, 0);       // R7 taken
    runInstr(2'b11, 1'b1, 4);       // R8 no operation
    for (int i = 0; i < 60; i++) begin
      runInstr(lfsr[2:1], lfsr[5], int'(lfsr[8:6]));
    end
    // Reset in the middle of an add (R1)
    opcode = 2'b00;
    memDone = 1'b1;
    repeat (4) @(negedge clk);
    doReset();
    #1;
    checkNow(opcode, negFlag);
    runInstr(2'b10, 1'b1, 1);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule